// File: doc/BRIEF.md
# Privilege-Gated Cycle Timestamp Counter

This block keeps a 64-bit count of clock cycles. The count starts at zero after reset and advances by one on every clock edge. An optional load port lets the surrounding logic preset the count. A read port lets the core ask for the count. Each read request carries three things: the current operating mode, the current privilege level and a timestamp-disable bit.

For each request the block decides whether the read is allowed. When it is, the block returns the count in two 32-bit halves one cycle later. When it is not, the block signals a general-protection fault in that same response slot. The fault comes with an error code of zero in the modes that carry one. The block does not decode instructions and does not deliver the fault to a handler.

Top module: `tsc_gate`

## Requirements
- R1: A cycle with `rst` high clears the count, so a read issued in the first cycle after reset is released returns 0.
- R2: The count increases by exactly one on every clock edge that has neither reset nor a load.
- R3: The count wraps from all-ones to zero. No flag or other output reports the wrap.
- R4: When `wr_en` is high, the count holds `wr_data` from the next cycle on. A read issued in the same cycle as the load returns the value from before the load.
- R5: Mode encoding is 0 = real, 1 = protected, 2 = virtual-8086, and 3 behaves as virtual-8086. With `rd_tsd` low, a read is allowed in every mode at every privilege level.
- R6: In protected mode with `rd_tsd` high, a read is allowed only at privilege level 0. At levels 1 to 3 it faults, with `flt_has_code` = 1 and `flt_code` = 0.
- R7: In real mode or virtual-8086 mode with `rd_tsd` high, every read faults. Real mode reports `flt_has_code` = 0. Virtual-8086 mode reports `flt_has_code` = 1 with `flt_code` = 0.
- R8: The response is due exactly one cycle after the request. `rsp_valid` is high and `{rsp_hi, rsp_lo}` equals the count held during the request cycle, with `rsp_hi` carrying bits 63:32 and `rsp_lo` carrying bits 31:0.
- R9: A faulting read keeps `rsp_valid` low and drives `rsp_hi` and `rsp_lo` to zero. It leaves the count running undisturbed.
- R10: A cycle without a request leaves both `rsp_valid` and `flt_valid` low in the following cycle. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request |
| rd_mode | input | 2 | Operating mode of the requester |
| rd_cpl | input | 2 | Current privilege level |
| rd_tsd | input | 1 | Timestamp-disable control bit |
| wr_en | input | 1 | Load the count |
| wr_data | input | 64 | Value to load |
| rsp_valid | output | 1 | Read granted; data valid |
| rsp_hi | output | 32 | Upper half of the sampled count |
| rsp_lo | output | 32 | Lower half of the sampled count |
| flt_valid | output | 1 | General-protection fault for the read |
| flt_has_code | output | 1 | Fault carries an error code |
| flt_code | output | 16 | Fault error code (always 0) |

## Verification
Every read result, whether data or fault, is due in the cycle after the request. The count itself changes on the edge after a load or reset. The bench drives inputs on the falling edge and samples the outputs on the next falling edge, one rising edge later. Expected counts are derived arithmetically: a loaded value V appears on a read issued in the next cycle, and a second read one cycle later must return V+1. Each access rule is swept over every mode, privilege level and disable setting, and each response is followed by a permitted read to confirm the count kept running.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int TSC_W   = 64;
    localparam int CODE_W  = 16;
    localparam int CPL_W   = 2;

    typedef enum logic [1:0] {
        OPM_REAL = 2'd0,
        OPM_PROT = 2'd1,
        OPM_V86  = 2'd2,
        OPM_RSVD = 2'd3
    } op_mode_e;

    typedef struct packed {
        logic grant;
        logic fault;
        logic has_code;
    } acc_verdict_t;

    // Access rule: disabled timestamp only readable at level 0 in protected mode.
    function automatic acc_verdict_t judge(input op_mode_e mode,
                                           input logic [CPL_W-1:0] cpl,
                                           input logic tsd);
        acc_verdict_t v;
        v.grant    = !tsd || (mode == OPM_PROT && cpl == '0);
        v.fault    = !v.grant;
        v.has_code = v.fault && (mode != OPM_REAL);
        return v;
    endfunction

endpackage

// File: rtl/tsc_counter.sv
module tsc_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] count_q
);

    always_ff @(posedge clk) begin
        if (rst)        count_q <= '0;
        else if (ld_en) count_q <= ld_val;
        else            count_q <= count_q + 1'b1;
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ld_en)) |-> count_q == $past(count_q) + 1'b1); // R2

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ld_en)) |-> count_q == $past(ld_val)); // R4

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> count_q == '0); // R1

endmodule

// File: rtl/tsc_access_check.sv
module tsc_access_check
    import tsc_pkg::*;
(
    input  logic [1:0]       mode,
    input  logic [CPL_W-1:0] cpl,
    input  logic             tsd,
    output acc_verdict_t     verdict
);

    op_mode_e m;

    always_comb begin
        m       = op_mode_e'(mode);
        verdict = judge(m, cpl, tsd);
    end

endmodule

// File: rtl/tsc_read_resp.sv
module tsc_read_resp
    import tsc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  acc_verdict_t      verdict,
    input  logic [CNT_W-1:0]  sample,
    output logic              ok_q,
    output logic              flt_q,
    output logic              has_code_q,
    output logic [CNT_W-1:0]  value_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ok_q       <= 1'b0;
            flt_q      <= 1'b0;
            has_code_q <= 1'b0;
            value_q    <= '0;
        end else begin
            ok_q       <= req && verdict.grant;
            flt_q      <= req && verdict.fault;
            has_code_q <= req && verdict.has_code;
            value_q    <= (req && verdict.grant) ? sample : '0;
        end
    end

    AST_SLOT_FILLED: assert property (@(posedge clk) disable iff (rst)
        req |=> (ok_q || flt_q)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req |=> (!ok_q && !flt_q)); // R10

    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(ok_q && flt_q)); // R10

    AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        flt_q |-> value_q == '0); // R9

    AST_DATA_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (req && verdict.grant) |=> value_q == $past(sample)); // R8

endmodule

// File: rtl/tsc_gate.sv
module tsc_gate
    import tsc_pkg::*;
#(
    parameter int CNT_W    = TSC_W,
    parameter bit HAS_LOAD = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_req,
    input  logic [1:0]          rd_mode,
    input  logic [CPL_W-1:0]    rd_cpl,
    input  logic                rd_tsd,
    input  logic                wr_en,
    input  logic [CNT_W-1:0]    wr_data,
    output logic                rsp_valid,
    output logic [CNT_W/2-1:0]  rsp_hi,
    output logic [CNT_W/2-1:0]  rsp_lo,
    output logic                flt_valid,
    output logic                flt_has_code,
    output logic [CODE_W-1:0]   flt_code
);

    localparam int HALF_W = CNT_W / 2;

    logic               ld_en;
    logic [CNT_W-1:0]   ld_val;
    logic [CNT_W-1:0]   count_q;
    logic [CNT_W-1:0]   value_q;
    acc_verdict_t       verdict;

    generate
        if (HAS_LOAD) begin : g_load
            assign ld_en  = wr_en;
            assign ld_val = wr_data;
        end else begin : g_noload
            assign ld_en  = 1'b0;
            assign ld_val = '0;
        end
    endgenerate

    tsc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_val  (ld_val),
        .count_q (count_q)
    );

    tsc_access_check u_chk (
        .mode    (rd_mode),
        .cpl     (rd_cpl),
        .tsd     (rd_tsd),
        .verdict (verdict)
    );

    tsc_read_resp #(.CNT_W(CNT_W)) u_resp (
        .clk        (clk),
        .rst        (rst),
        .req        (rd_req),
        .verdict    (verdict),
        .sample     (count_q),
        .ok_q       (rsp_valid),
        .flt_q      (flt_valid),
        .has_code_q (flt_has_code),
        .value_q    (value_q)
    );

    assign rsp_hi   = value_q[CNT_W-1:HALF_W];
    assign rsp_lo   = value_q[HALF_W-1:0];
    assign flt_code = '0;

    AST_DISABLED_OUTSIDE_PROT: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_tsd && rd_mode != 2'd1) |=> flt_valid); // R7

    AST_PROT_USER_FAULTS: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_tsd && rd_mode == 2'd1 && rd_cpl != '0) |=> (flt_valid && flt_has_code)); // R6

    AST_ENABLED_GRANTS: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_tsd) |=> rsp_valid); // R5

    AST_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
        flt_valid |-> flt_code == '0); // R6

endmodule

// File: tb/tsc_gate_tb.sv
`timescale 1ns/100ps
module tsc_gate_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        rd_req;
    logic [1:0]  rd_mode;
    logic [1:0]  rd_cpl;
    logic        rd_tsd;
    logic        wr_en;
    logic [63:0] wr_data;
    logic        rsp_valid;
    logic [31:0] rsp_hi;
    logic [31:0] rsp_lo;
    logic        flt_valid;
    logic        flt_has_code;
    logic [15:0] flt_code;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tsc_gate dut_i (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_mode(rd_mode), .rd_cpl(rd_cpl),
        .rd_tsd(rd_tsd), .wr_en(wr_en), .wr_data(wr_data), .rsp_valid(rsp_valid),
        .rsp_hi(rsp_hi), .rsp_lo(rsp_lo), .flt_valid(flt_valid),
        .flt_has_code(flt_has_code), .flt_code(flt_code)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        rd_req = 0; rd_mode = 0; rd_cpl = 0; rd_tsd = 0; wr_en = 0; wr_data = '0;
    endtask

    // Load v, then read with given attributes, then read with tsd low.
    task automatic load_and_read(input logic [63:0] v, input logic [1:0] m,
                                 input logic [1:0] c, input logic t, input string tag);
        logic exp_ok;
        logic exp_code;
        exp_ok   = !t || (m == 2'd1 && c == 2'd0);
        exp_code = !exp_ok && (m != 2'd0);
        idle_inputs(); wr_en = 1; wr_data = v;
        step();
        idle_inputs(); rd_req = 1; rd_mode = m; rd_cpl = c; rd_tsd = t;
        step();
        chk({tag, " rsp_valid"}, {63'd0, rsp_valid}, {63'd0, exp_ok});
        chk({tag, " flt_valid"}, {63'd0, flt_valid}, {63'd0, !exp_ok});
        chk({tag, " flt_has_code"}, {63'd0, flt_has_code}, {63'd0, exp_code});
        chk({tag, " flt_code"}, {48'd0, flt_code}, 64'd0);
        chk({tag, " data"}, {rsp_hi, rsp_lo}, exp_ok ? v : 64'd0);
        idle_inputs(); rd_req = 1; rd_mode = m; rd_cpl = c; rd_tsd = 0;
        step();
        chk({tag, " R9 count kept running"}, {rsp_hi, rsp_lo}, v + 64'd1);
        idle_inputs();
    endtask

    initial begin
        #(5.0 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: read in first cycle after reset returns 0
        rd_req = 1; rd_mode = 2'd1; rd_cpl = 2'd3; rd_tsd = 0;
        step();
        chk("R1 reset value", {rsp_hi, rsp_lo}, 64'd0);
        chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd1);
        // R2: back-to-back reads step by one; then gap of 5 idle cycles
        step();
        chk("R2 next read", {rsp_hi, rsp_lo}, 64'd1);
        idle_inputs();
        step();
        chk("R10 idle rsp_valid", {63'd0, rsp_valid}, 64'd0);
        chk("R10 idle flt_valid", {63'd0, flt_valid}, 64'd0);
        repeat (4) step();
        rd_req = 1;
        step();
        chk("R2 after gap", {rsp_hi, rsp_lo}, 64'd7);

        // R5 R6 R7 R8 R9: exhaustive access sweep
        for (int m = 0; m < 4; m++)
            for (int c = 0; c < 4; c++)
                for (int t = 0; t < 2; t++)
                    load_and_read(64'h0123_4567_89AB_0000 + 64'h1_0000_0101 * (m*8 + c*2 + t),
                                  m[1:0], c[1:0], t[0],
                                  $sformatf("R5/R6/R7/R8 m%0d c%0d t%0d", m, c, t));

        // R8 split halves with distinct patterns
        load_and_read(64'hDEAD_BEEF_0000_FFFF, 2'd0, 2'd2, 1'b0, "R8 halves");

        // R3: wrap
        load_and_read(64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 2'd0, 1'b0, "R3 wrap");

        // R4: load and read in the same cycle
        idle_inputs(); wr_en = 1; wr_data = 64'h0000_0000_0000_1000;
        step();
        idle_inputs(); rd_req = 1; wr_en = 1; wr_data = 64'hABCD_0000_0000_0042;
        step();
        chk("R4 same-cycle read sees old", {rsp_hi, rsp_lo}, 64'h1000);
        idle_inputs(); rd_req = 1;
        step();
        chk("R4 load visible", {rsp_hi, rsp_lo}, 64'hABCD_0000_0000_0042);
        idle_inputs();
        step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule